// File: doc/BRIEF.md
# Load Result Formatter

This block turns the raw bytes of a completed 1-, 2-, 4- or 8-byte load into the 64-bit value written to the destination register. A single registered stage applies one of three placements to the loaded field: zero extension, sign extension, or byte-reversed placement with zero fill. The raw word comes from the memory side right-aligned. The field occupies the low bytes of `raw_i`, and the first addressed byte is the most significant byte of that field.

Some pairings of access size and mode have no defined result. When one of them is requested, the block raises an illegal-mode flag and delivers zero, and the pipeline can squash or trap on that flag. Address generation, alignment and the memory interface are handled elsewhere.

Top module: `ld_result_fmt`

## Requirements
- R1: `size_i` encodes the access width: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes, and 3 means 8 bytes. `mode_i` encodes the placement: 0 is zero extend, 1 is sign extend, 2 is byte reverse, and 3 is reserved. For an access of N bytes, the field is `raw_i[8N-1:0]`, and its first addressed byte is `raw_i[8N-1:8N-8]`.
- R2: A 1-byte zero-extend load puts `raw_i[7:0]` in `result_o[7:0]` and clears `result_o[63:8]`.
- R3: A 2-byte or 4-byte zero-extend load copies the field into the low 16 or 32 result bits and clears every bit above them.
- R4: A 2-byte or 4-byte sign-extend load copies the field into the low result bits and fills every bit above them with the field's top bit (bit 15 or bit 31).
- R5: An 8-byte zero-extend load passes `raw_i` to `result_o` unchanged.
- R6: A 2-byte byte-reverse load swaps the two field bytes into `result_o[15:0]` and clears `result_o[63:16]`.
- R7: A 4-byte byte-reverse load places the first addressed byte in `result_o[7:0]` and the last addressed byte in `result_o[31:24]`, and clears `result_o[63:32]`.
- R8: An 8-byte byte-reverse load reverses the order of all eight bytes across the result.
- R9: The following pairings are illegal: sign extend with size 0 or 3, byte reverse with size 0, and any use of mode 3. An illegal pairing sets `illegal_o` and drives `result_o` to zero. `illegal_o` is low for every other pairing.
- R10: `valid_o` equals `valid_i` delayed by one clock. In a cycle where `valid_o` is low, `result_o` is zero and `illegal_o` is low.
- R11: While `rst_ni` is low, `valid_o`, `illegal_o` and `result_o` are all zero.
- R12: Bits of `raw_i` above the accessed field have no effect on `result_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Load data present this cycle |
| size_i | input | 2 | Access width code |
| mode_i | input | 2 | Placement mode code |
| raw_i | input | 64 | Raw load data, field right-aligned |
| valid_o | output | 1 | Result present |
| result_o | output | 64 | Formatted register value |
| illegal_o | output | 1 | Size and mode pairing is undefined |

## Verification
The in-line properties check four behaviours on every clock:
- the one-cycle valid latency;
- quiet outputs when no result is present;
- the illegal-pairing decode together with its zeroed result;
- the plain byte and doubleword placements.

The sign fill of the halfword and word cases, the byte order of the reversed forms, and the insensitivity to bits above the field only show up through the bench's scenarios. There, random raw words with both sign polarities are compared against a byte-by-byte reference model.

// File: rtl/ld_fmt_pkg.sv
package ld_fmt_pkg;
  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } ld_size_e;

  typedef enum logic [1:0] {
    MD_ZERO = 2'd0,
    MD_SIGN = 2'd1,
    MD_REV  = 2'd2,
    MD_RSVD = 2'd3
  } ld_mode_e;
endpackage

// File: rtl/ld_fmt_legal.sv
module ld_fmt_legal
  import ld_fmt_pkg::*;
(
  input  logic [1:0] size_i,
  input  logic [1:0] mode_i,
  output logic       legal_o
);
  ld_size_e sz;
  ld_mode_e md;

  assign sz = ld_size_e'(size_i);
  assign md = ld_mode_e'(mode_i);

  always_comb begin
    unique case (md)
      MD_ZERO: legal_o = 1'b1;
      MD_SIGN: legal_o = (sz == SZ_H) || (sz == SZ_W);
      MD_REV:  legal_o = (sz != SZ_B);
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ld_fmt_ext.sv
module ld_fmt_ext #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  localparam int NUM_BYTES = DATA_W / BYTE_W,
  localparam int NUM_SIZES = $clog2(NUM_BYTES) + 1,
  localparam int SIZE_W    = $clog2(NUM_SIZES)
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              sign_en_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] ext_v [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int FW = BYTE_W << g;
    if (FW >= DATA_W) begin : g_full
      assign ext_v[g] = raw_i;
    end else begin : g_part
      logic fill;
      assign fill     = sign_en_i & raw_i[FW-1];
      assign ext_v[g] = {{(DATA_W-FW){fill}}, raw_i[FW-1:0]};
    end
  end

  assign data_o = ext_v[size_i];
endmodule

// File: rtl/ld_fmt_swap.sv
module ld_fmt_swap #(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  localparam int NUM_BYTES = DATA_W / BYTE_W,
  localparam int NUM_SIZES = $clog2(NUM_BYTES) + 1,
  localparam int SIZE_W    = $clog2(NUM_SIZES)
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] swp_v [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int NB = 1 << g;
    localparam int FW = NB * BYTE_W;
    logic [FW-1:0] field_rev;
    for (genvar b = 0; b < NB; b++) begin : g_byte
      // first addressed byte (field MSB) lands in result byte 0
      assign field_rev[b*BYTE_W +: BYTE_W] = raw_i[(NB-1-b)*BYTE_W +: BYTE_W];
    end
    if (FW >= DATA_W) begin : g_full
      assign swp_v[g] = field_rev;
    end else begin : g_part
      assign swp_v[g] = {{(DATA_W-FW){1'b0}}, field_rev};
    end
  end

  assign data_o = swp_v[size_i];
endmodule

// File: rtl/ld_result_fmt.sv
module ld_result_fmt
  import ld_fmt_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  localparam int NUM_BYTES = DATA_W / BYTE_W,
  localparam int NUM_SIZES = $clog2(NUM_BYTES) + 1,
  localparam int SIZE_W    = $clog2(NUM_SIZES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] raw_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  logic              legal;
  logic [DATA_W-1:0] ext_data;
  logic [DATA_W-1:0] swp_data;
  logic [DATA_W-1:0] fmt_d;
  logic              valid_q;
  logic              illegal_q;
  logic [DATA_W-1:0] result_q;

  ld_fmt_legal u_legal (
    .size_i (size_i),
    .mode_i (mode_i),
    .legal_o(legal)
  );

  ld_fmt_ext #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ext (
    .raw_i    (raw_i),
    .size_i   (size_i),
    .sign_en_i(mode_i == MD_SIGN),
    .data_o   (ext_data)
  );

  ld_fmt_swap #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_swap (
    .raw_i (raw_i),
    .size_i(size_i),
    .data_o(swp_data)
  );

  always_comb begin
    if (!legal)                fmt_d = '0;
    else if (mode_i == MD_REV) fmt_d = swp_data;
    else                       fmt_d = ext_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      result_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        illegal_q <= ~legal;
        result_q  <= fmt_d;
      end else begin
        illegal_q <= 1'b0;
        result_q  <= '0;
      end
    end
  end

  assign valid_o   = valid_q;
  assign illegal_o = illegal_q;
  assign result_o  = result_q;

  p_valid_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (result_o == '0) && !illegal_o);

  p_illegal_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> result_o == '0);

  p_illegal_decode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> illegal_o == (($past(mode_i) == MD_RSVD)
      || ($past(mode_i) == MD_SIGN && ($past(size_i) == SZ_B || $past(size_i) == SZ_D))
      || ($past(mode_i) == MD_REV && $past(size_i) == SZ_B)));

  p_byte_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && size_i == SZ_B && mode_i == MD_ZERO |=>
      result_o == {{(DATA_W-BYTE_W){1'b0}}, $past(raw_i[BYTE_W-1:0])});

  p_dword_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && size_i == SZ_D && mode_i == MD_ZERO |=> result_o == $past(raw_i));
endmodule

// File: tb/sim_ld_result_fmt.sv
module sim_ld_result_fmt;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  size_i = '0;
  logic [1:0]  mode_i = '0;
  logic [63:0] raw_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic        illegal_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  ld_result_fmt u0 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .size_i   (size_i),
    .mode_i   (mode_i),
    .raw_i    (raw_i),
    .valid_o  (valid_o),
    .result_o (result_o),
    .illegal_o(illegal_o)
  );

  function automatic bit is_legal(input logic [1:0] sz, input logic [1:0] md);
    if (md == 2'd0) return 1'b1;
    if (md == 2'd1) return (sz == 2'd1) || (sz == 2'd2);
    if (md == 2'd2) return sz != 2'd0;
    return 1'b0;
  endfunction

  function automatic logic [63:0] model(input logic [1:0] sz, input logic [1:0] md,
                                        input logic [63:0] raw);
    logic [63:0] r;
    int n;
    n = 1 << sz;
    r = '0;
    if (!is_legal(sz, md)) return '0;
    for (int b = 0; b < n; b++) begin
      if (md == 2'd2) r[8*(n-1-b) +: 8] = raw[8*b +: 8];
      else            r[8*b +: 8] = raw[8*b +: 8];
    end
    if (md == 2'd1 && raw[8*n-1])
      for (int b = n; b < 8; b++) r[8*b +: 8] = 8'hff;
    return r;
  endfunction

  function automatic string tag_of(input logic [1:0] sz, input logic [1:0] md);
    if (!is_legal(sz, md)) return "R9";
    if (md == 2'd1) return "R4";
    if (md == 2'd2) return (sz == 2'd1) ? "R6" : (sz == 2'd2) ? "R7" : "R8";
    return (sz == 2'd0) ? "R2" : (sz == 2'd3) ? "R5" : "R3";
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, capture at posedge, sample 1 ns later
  task automatic apply(input logic [1:0] sz, input logic [1:0] md, input logic [63:0] raw,
                       input string tag);
    @(negedge clk_i);
    valid_i = 1'b1; size_i = sz; mode_i = md; raw_i = raw;
    @(posedge clk_i); #1;
    check({tag, " R10 valid"}, {63'd0, valid_o}, 64'd1);
    check({tag, " R9 flag"}, {63'd0, illegal_o}, {63'd0, !is_legal(sz, md)});
    check(tag, result_o, model(sz, md, raw));
  endtask

  task automatic idle();
    @(negedge clk_i);
    valid_i = 1'b0; raw_i = 64'hdead_beef_cafe_f00d; size_i = 2'd3; mode_i = 2'd0;
    @(posedge clk_i); #1;
    check("R10 idle valid", {63'd0, valid_o}, 64'd0);
    check("R10 idle result", result_o, 64'd0);
    check("R10 idle flag", {63'd0, illegal_o}, 64'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] w;
    void'($urandom(32'd20240611));
    valid_i = 1'b1; raw_i = '1; size_i = 2'd3; mode_i = 2'd0;
    repeat (3) @(posedge clk_i);
    #1;
    check("R11 reset valid", {63'd0, valid_o}, 64'd0);
    check("R11 reset result", result_o, 64'd0);
    check("R11 reset flag", {63'd0, illegal_o}, 64'd0);
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b1;
    idle();

    w = 64'h8182_8384_8586_8788;
    apply(2'd0, 2'd0, w, "R2 byte");
    apply(2'd1, 2'd0, w, "R3 half zero");
    apply(2'd2, 2'd0, w, "R3 word zero");
    apply(2'd1, 2'd1, w, "R4 half sign neg");
    apply(2'd2, 2'd1, w, "R4 word sign neg");
    apply(2'd1, 2'd1, 64'hffff_ffff_ffff_7fff, "R4 half sign pos R12");
    apply(2'd2, 2'd1, 64'h0000_0000_7fff_ffff, "R4 word sign pos");
    apply(2'd3, 2'd0, w, "R5 dword");
    apply(2'd1, 2'd2, 64'hffff_ffff_ffff_a1b2, "R6 rev half");
    check("R6 literal", result_o, 64'h0000_0000_0000_b2a1);
    apply(2'd2, 2'd2, 64'h1111_1111_0102_0304, "R7 rev word");
    check("R7 literal", result_o, 64'h0000_0000_0403_0201);
    apply(2'd3, 2'd2, 64'h0102_0304_0506_0708, "R8 rev dword");
    check("R8 literal", result_o, 64'h0807_0605_0403_0201);
    apply(2'd0, 2'd1, w, "R9 sign byte");
    apply(2'd3, 2'd1, w, "R9 sign dword");
    apply(2'd0, 2'd2, w, "R9 rev byte");
    apply(2'd2, 2'd3, w, "R9 reserved");
    apply(2'd0, 2'd0, 64'hffff_ffff_ffff_ff5a, "R12 byte upper ignored");
    check("R12 literal", result_o, 64'h0000_0000_0000_005a);
    idle();

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] sz, md;
      sz = 2'($urandom_range(0, 3));
      md = 2'($urandom_range(0, 3));
      w = {$urandom(), $urandom()};
      if ($urandom_range(0, 3) == 0) w[8*(1<<sz)-1] = ~w[8*(1<<sz)-1];
      apply(sz, md, w, {"R1 ", tag_of(sz, md)});
      if ($urandom_range(0, 7) == 0) idle();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule